// File: doc/BRIEF.md
# Four-Channel Bus-Mastering Transfer Controller

This block moves single bytes between peripherals and memory without the CPU touching the data. It serves four request lines. When an enabled channel asks for service, the controller requests the system bus. It waits for the grant, then spends one cycle publishing the 16-bit memory address and one cycle strobing the transfer. After each transfer it hands the bus back and decides again. Each channel carries a 16-bit address that increments after every transfer and a 16-bit count that decrements. A block is therefore up to 65,536 transfers long, with the count programmed as length minus one.

While the controller does not own the bus, the CPU programs it over an 8-bit data bus, selecting a register on four address lines. Sixteen-bit registers go through in two byte accesses, steered by an internal byte pointer. In the address cycle the same four lines become outputs carrying address bits 3:0, and four extra lines carry bits 7:4. The high address byte goes out on the data bus together with a latch strobe, so external logic can capture it. The data bus is then released for the transfer cycle.

Arbitration is either fixed, with channel 0 first, or rotating, with the channel just served going last.

Top module: `dma4_ctrl`

## Requirements
- R1: `hrq` rises after an enabled channel raises its request, and `aen` rises only in a cycle after `hlda` was seen high. `hrq` stays high for as long as `aen` is high.
- R2: Each transfer is an address cycle followed by a transfer cycle. In the address cycle `adstb`, `aen` and `data_oe` are high, `data_out` carries address bits 15:8, `addr_mid` carries bits 7:4 and `addr_out` carries bits 3:0. In the transfer cycle `dack` is one-hot for the served channel and `data_oe` is low.
- R3: In the transfer cycle, a channel whose direction bit is 1 asserts `mem_rd` and `io_wr` together, moving data from memory to the peripheral. A direction bit of 0 asserts `io_rd` and `mem_wr` together. The two pairs are never active at the same time.
- R4: Fixed priority (rotate bit 0) always serves the lowest-numbered pending channel.
- R5: Rotating priority (rotate bit 1) puts the channel after the last one served first and wraps from 3 to 0.
- R6: Register select codes are as follows. For `sel[3]`=0, `sel[2:1]` is the channel and `sel[0]` chooses address (0) or count (1). Code 1000 is a mode write or a status read. Code 1001 is the rotate register, bit 0. Each access to a channel register takes the low byte first and then the high byte, alternating.
- R7: A mode write returns the byte pointer to the low byte.
- R8: After each transfer the served channel's address increments by 1 and its count decrements by 1.
- R9: A transfer made while the count is 0 does three things. It raises `tc` with the strobes, sets that channel's status bit, and clears that channel's enable bit, so no further transfers take place.
- R10: Status byte bits 3:0 are the terminal-count flags and bits 7:4 are the raw request lines. Reading the status clears the flags.
- R11: Mode bits 3:0 enable channels 0–3 and mode bits 7:4 are their direction bits. A request on a disabled channel raises neither `hrq` nor `dack`.
- R12: After reset, all strobes, `hrq`, `aen`, `tc`, `dack` and `data_oe` are low, and the status flags read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cs | input | 1 | CPU chip select |
| cpu_rd | input | 1 | CPU register read, one cycle |
| cpu_wr | input | 1 | CPU register write, one cycle |
| addr_in | input | 4 | Register select (slave side of low address lines) |
| addr_out | output | 4 | Memory address bits 3:0 (master side) |
| addr_oe | output | 1 | Drive enable for low address lines |
| addr_mid | output | 4 | Memory address bits 7:4 |
| data_in | input | 8 | Data bus, inbound |
| data_out | output | 8 | Data bus, outbound (read data or address bits 15:8) |
| data_oe | output | 1 | Data bus drive enable |
| drq | input | 4 | Channel requests |
| dack | output | 4 | Channel acknowledges / device strobes |
| hrq | output | 1 | Bus hold request |
| hlda | input | 1 | Bus hold grant |
| aen | output | 1 | Address enable, controller owns the bus |
| adstb | output | 1 | Strobe latching address bits 15:8 from the data bus |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| io_rd | output | 1 | Peripheral read strobe |
| io_wr | output | 1 | Peripheral write strobe |
| tc | output | 1 | Terminal count, final transfer of a block |

## Verification
The bound checker watches the bus-side protocol on every cycle. It checks that the grant comes before the address enable and that the address strobe leads straight into a one-hot acknowledge with the data bus released. It also checks that the strobe pairs stay exclusive, that terminal count only appears with an acknowledge, and that no disabled channel is ever acknowledged. Other behaviour needs the bench's scenarios. These include which channel wins under fixed versus rotating priority, the exact address sequence and count exhaustion, and the byte-pointer ordering of register access. Clearing of the status flags by a read, and the blocked channel staying quiet after its count ends, are also shown only there.

// File: rtl/dma4_pkg.sv
package dma4_pkg;
  parameter int unsigned NCH    = 4;
  parameter int unsigned WORD_W = 16;
  localparam int unsigned CHW   = $clog2(NCH);

  typedef enum logic [1:0] {ST_IDLE, ST_REQ, ST_ADDR, ST_XFER} dma_state_t;

  // first pending channel at or after 'first', wrapping
  function automatic logic [CHW-1:0] pick_chan(input logic [NCH-1:0] req,
                                               input logic [CHW-1:0] first);
    logic [CHW-1:0] r;
    r = first;
    for (int i = NCH - 1; i >= 0; i--) begin
      if (req[CHW'((int'(first) + i) % NCH)]) r = CHW'((int'(first) + i) % NCH);
    end
    return r;
  endfunction

  function automatic logic [CHW-1:0] start_chan(input logic rot, input logic [CHW-1:0] last);
    return rot ? CHW'((int'(last) + 1) % NCH) : '0;
  endfunction

  function automatic logic [WORD_W-1:0] put_byte(input logic [WORD_W-1:0] v,
                                                 input logic hi, input logic [7:0] b);
    logic [WORD_W-1:0] r;
    r = v;
    if (hi) r[WORD_W-1:8] = b[WORD_W-9:0];
    else    r[7:0]        = b;
    return r;
  endfunction

  function automatic logic [7:0] get_byte(input logic [WORD_W-1:0] v, input logic hi);
    return hi ? 8'(v[WORD_W-1:8]) : v[7:0];
  endfunction
endpackage

// File: rtl/dma4_regfile.sv
module dma4_regfile
  import dma4_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_stb,
  input  logic              rd_stb,
  input  logic [3:0]        sel,
  input  logic [7:0]        wdata,
  output logic [7:0]        rdata,
  input  logic [NCH-1:0]    req_vis,
  input  logic              upd,
  input  logic [CHW-1:0]    upd_ch,
  output logic [NCH-1:0]    ch_en,
  output logic [NCH-1:0]    dir_mr,
  output logic              rotate,
  output logic [WORD_W-1:0] cur_addr,
  output logic              cur_last
);
  localparam logic [3:0] SEL_MODE = 4'b1000;
  localparam logic [3:0] SEL_ROT  = 4'b1001;

  logic [WORD_W-1:0] addr_v [NCH];
  logic [WORD_W-1:0] cnt_v  [NCH];
  logic              ff_q, rot_q;
  logic [7:0]        mode_q;
  logic [NCH-1:0]    tcf_q;
  logic              chan_sel;

  assign chan_sel = !sel[3];

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic [WORD_W-1:0] a_q, n_q;
    logic              hit, served;
    assign hit    = wr_stb && chan_sel && (sel[2:1] == CHW'(c));
    assign served = upd && (upd_ch == CHW'(c));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        a_q <= '0;
        n_q <= '0;
      end else if (served) begin
        a_q <= a_q + 1'b1;
        if (n_q != '0) n_q <= n_q - 1'b1;
      end else if (hit) begin
        if (!sel[0]) a_q <= put_byte(a_q, ff_q, wdata);
        else         n_q <= put_byte(n_q, ff_q, wdata);
      end
    end
    assign addr_v[c] = a_q;
    assign cnt_v[c]  = n_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ff_q   <= 1'b0;
      rot_q  <= 1'b0;
      mode_q <= '0;
      tcf_q  <= '0;
    end else begin
      if ((wr_stb || rd_stb) && chan_sel) ff_q <= !ff_q;
      if (wr_stb && sel == SEL_MODE) begin
        mode_q <= wdata;
        ff_q   <= 1'b0;
      end
      if (wr_stb && sel == SEL_ROT) rot_q <= wdata[0];
      if (rd_stb && sel == SEL_MODE) tcf_q <= '0;
      if (upd && cnt_v[upd_ch] == '0) begin
        tcf_q[upd_ch]  <= 1'b1;
        mode_q[upd_ch] <= 1'b0;
      end
    end
  end

  always_comb begin
    rdata = '0;
    if (chan_sel)
      rdata = get_byte(sel[0] ? cnt_v[sel[2:1]] : addr_v[sel[2:1]], ff_q);
    else if (sel == SEL_MODE)
      rdata = {req_vis, tcf_q};
    else if (sel == SEL_ROT)
      rdata = {7'b0, rot_q};
  end

  assign ch_en    = mode_q[NCH-1:0];
  assign dir_mr   = mode_q[7:4];
  assign rotate   = rot_q;
  assign cur_addr = addr_v[upd_ch];
  assign cur_last = (cnt_v[upd_ch] == '0);
endmodule

// File: rtl/dma4_arb.sv
module dma4_arb
  import dma4_pkg::*;
(
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] req,
  input  logic           rotate,
  input  logic           take,
  output logic [CHW-1:0] pick,
  output logic           any
);
  logic [CHW-1:0] last_q;

  assign pick = pick_chan(req, start_chan(rotate, last_q));
  assign any  = |req;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    last_q <= CHW'(NCH - 1);
    else if (take) last_q <= pick;
  end
endmodule

// File: rtl/dma4_ctrl.sv
module dma4_ctrl
  import dma4_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cs,
  input  logic       cpu_rd,
  input  logic       cpu_wr,
  input  logic [3:0] addr_in,
  output logic [3:0] addr_out,
  output logic       addr_oe,
  output logic [3:0] addr_mid,
  input  logic [7:0] data_in,
  output logic [7:0] data_out,
  output logic       data_oe,
  input  logic [3:0] drq,
  output logic [3:0] dack,
  output logic       hrq,
  input  logic       hlda,
  output logic       aen,
  output logic       adstb,
  output logic       mem_rd,
  output logic       mem_wr,
  output logic       io_rd,
  output logic       io_wr,
  output logic       tc
);
  dma_state_t        state_q, state_d;
  logic [CHW-1:0]    ch_q, pick;
  logic [NCH-1:0]    ch_en, dir_mr, eligible;
  logic              rotate, any, take, upd, master, in_addr, in_xfer;
  logic              slave_wr, slave_rd, cur_last;
  logic [WORD_W-1:0] cur_addr;
  logic [7:0]        reg_rdata;

  assign in_addr  = (state_q == ST_ADDR);
  assign in_xfer  = (state_q == ST_XFER);
  assign master   = in_addr || in_xfer;
  assign slave_wr = cs && cpu_wr && !master;
  assign slave_rd = cs && cpu_rd && !master;
  assign eligible = drq & ch_en;
  assign take     = (state_q == ST_REQ) && hlda && any;
  assign upd      = in_xfer;

  dma4_regfile regs_i (
    .clk, .rst_n, .wr_stb(slave_wr), .rd_stb(slave_rd), .sel(addr_in),
    .wdata(data_in), .rdata(reg_rdata), .req_vis(drq), .upd, .upd_ch(ch_q),
    .ch_en, .dir_mr, .rotate, .cur_addr, .cur_last
  );

  dma4_arb arb_i (
    .clk, .rst_n, .req(eligible), .rotate, .take, .pick, .any
  );

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE: if (any) state_d = ST_REQ;
      ST_REQ:  if (!any) state_d = ST_IDLE;
               else if (hlda) state_d = ST_ADDR;
      ST_ADDR: state_d = ST_XFER;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      ch_q    <= '0;
    end else begin
      state_q <= state_d;
      if (take) ch_q <= pick;
    end
  end

  assign hrq      = (state_q != ST_IDLE);
  assign aen      = master;
  assign adstb    = in_addr;
  assign addr_oe  = master;
  assign addr_out = master ? cur_addr[3:0] : 4'h0;
  assign addr_mid = master ? cur_addr[7:4] : 4'h0;
  assign data_out = in_addr ? cur_addr[WORD_W-1:8] : reg_rdata;
  assign data_oe  = in_addr || slave_rd;
  assign dack     = in_xfer ? (NCH'(1) << ch_q) : '0;
  assign mem_rd   = in_xfer && dir_mr[ch_q];
  assign io_wr    = in_xfer && dir_mr[ch_q];
  assign io_rd    = in_xfer && !dir_mr[ch_q];
  assign mem_wr   = in_xfer && !dir_mr[ch_q];
  assign tc       = in_xfer && cur_last;
endmodule

// File: rtl/dma4_ctrl_chk.sv
module dma4_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       hrq,
  input logic       hlda,
  input logic       aen,
  input logic       adstb,
  input logic       data_oe,
  input logic [3:0] dack,
  input logic       mem_rd,
  input logic       mem_wr,
  input logic       io_rd,
  input logic       io_wr,
  input logic       tc,
  input logic [3:0] ch_en
);
  // R1
  grant_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(aen) |-> $past(hlda));
  // R1
  hold_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    aen |-> hrq);
  // R2
  addr_then_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    adstb |=> ($onehot(dack) && !data_oe && aen));
  // R2
  ack_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(dack));
  // R3
  mem_to_io_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd || io_wr) |-> (mem_rd && io_wr && !io_rd && !mem_wr));
  // R3
  io_to_mem_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (io_rd || mem_wr) |-> (io_rd && mem_wr && !mem_rd && !io_wr));
  // R3
  strobe_has_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd || mem_wr) |-> (|dack));
  // R9
  tc_has_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tc |-> (|dack));
  // R11
  ack_enabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|dack) |-> (|(dack & ch_en)));
endmodule

bind dma4_ctrl dma4_ctrl_chk chk_i (
  .clk(clk), .rst_n(rst_n), .hrq(hrq), .hlda(hlda), .aen(aen), .adstb(adstb),
  .data_oe(data_oe), .dack(dack), .mem_rd(mem_rd), .mem_wr(mem_wr),
  .io_rd(io_rd), .io_wr(io_wr), .tc(tc), .ch_en(ch_en)
);

// File: tb/dma4_ctrl_tb_top.sv
module dma4_ctrl_tb_top;
  logic       clk = 1'b0, rst_n = 1'b0;
  logic       cs = 0, cpu_rd = 0, cpu_wr = 0, hlda = 0;
  logic [3:0] addr_in = 0, drq = 0;
  logic [7:0] data_in = 0;
  logic [3:0] addr_out, addr_mid, dack;
  logic [7:0] data_out;
  logic       addr_oe, data_oe, hrq, aen, adstb, mem_rd, mem_wr, io_rd, io_wr, tc;
  int         n_chk = 0, n_fail = 0;

  always #2 clk = !clk;

  dma4_ctrl dut_i (.*);

  // bus owner model: grant follows request
  initial forever begin
    @(negedge clk);
    hlda = hrq;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #400000;
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  task automatic cpu_write(input logic [3:0] sel, input logic [7:0] v);
    @(negedge clk);
    cs = 1; cpu_wr = 1; addr_in = sel; data_in = v;
    @(negedge clk);
    cs = 0; cpu_wr = 0;
  endtask

  task automatic cpu_read(input logic [3:0] sel, output logic [7:0] v);
    @(negedge clk);
    cs = 1; cpu_rd = 1; addr_in = sel;
    #1 v = data_out;
    @(negedge clk);
    cs = 0; cpu_rd = 0;
  endtask

  task automatic write16(input logic [3:0] sel, input logic [15:0] v);
    cpu_write(sel, v[7:0]);
    cpu_write(sel, v[15:8]);
  endtask

  // wait for one transfer and check both of its cycles
  task automatic do_xfer(input int ch, input logic [15:0] a, input bit m2p, input bit last);
    bit found = 0;
    for (int n = 0; n < 40 && !found; n++) begin
      @(negedge clk); #1;
      if (adstb) found = 1;
    end
    chk(found, "R1", "address cycle reached", found, 1);
    chk(hlda && hrq && aen, "R1", "grant before address", {hlda, hrq, aen}, 3'b111);
    chk(data_oe && data_out == a[15:8], "R2", "high address byte", data_out, a[15:8]);
    chk(addr_mid == a[7:4] && addr_out == a[3:0] && addr_oe, "R2", "low address bits",
        {addr_mid, addr_out}, a[7:0]);
    @(negedge clk); #1;
    chk(dack == 4'(1 << ch) && !data_oe, "R2", "ack and bus released", dack, 4'(1 << ch));
    chk({mem_rd, io_wr, io_rd, mem_wr} == (m2p ? 4'b1100 : 4'b0011), "R3", "strobe pair",
        {mem_rd, io_wr, io_rd, mem_wr}, m2p ? 4'b1100 : 4'b0011);
    chk(tc == last, "R9", "terminal count", tc, last);
  endtask

  task automatic t_reset();
    logic [7:0] v;
    chk({hrq, aen, tc, data_oe, mem_rd, mem_wr, io_rd, io_wr} == 0 && dack == 0,
        "R12", "idle outputs", {hrq, aen, tc, data_oe, dack}, 0);
    cpu_read(4'b1000, v);
    chk(v == 8'h00, "R12", "status after reset", v, 0);
  endtask

  task automatic t_regs();
    logic [7:0] lo, hi;
    write16(4'b0010, 16'h1234);
    write16(4'b0011, 16'h0002);
    cpu_read(4'b0010, lo); cpu_read(4'b0010, hi);
    chk({hi, lo} == 16'h1234, "R6", "ch1 address readback", {hi, lo}, 16'h1234);
    cpu_read(4'b0011, lo); cpu_read(4'b0011, hi);
    chk({hi, lo} == 16'h0002, "R6", "ch1 count readback", {hi, lo}, 16'h0002);
  endtask

  task automatic t_ptr_reset();
    logic [7:0] lo, hi;
    cpu_write(4'b0100, 8'h77);
    cpu_write(4'b1000, 8'h00);
    write16(4'b0100, 16'hCDAB);
    cpu_read(4'b0100, lo); cpu_read(4'b0100, hi);
    chk({hi, lo} == 16'hCDAB, "R7", "pointer reset by mode write", {hi, lo}, 16'hCDAB);
  endtask

  task automatic t_disabled();
    logic [7:0] v;
    bit seen = 0;
    drq = 4'b0010;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk); #1;
      if (hrq || dack != 0) seen = 1;
    end
    chk(!seen, "R11", "disabled channel ignored", seen, 0);
    cpu_read(4'b1000, v);
    chk(v == 8'h20, "R10", "status shows raw request", v, 8'h20);
    drq = 0;
  endtask

  task automatic t_block();
    logic [7:0] v, lo, hi;
    bit seen = 0;
    cpu_write(4'b1000, 8'h02);
    drq = 4'b0010;
    do_xfer(1, 16'h1234, 0, 0);
    do_xfer(1, 16'h1235, 0, 0);
    do_xfer(1, 16'h1236, 0, 1);
    for (int i = 0; i < 8; i++) begin
      @(negedge clk); #1;
      if (hrq) seen = 1;
    end
    chk(!seen, "R9", "channel stops after terminal count", seen, 0);
    cpu_read(4'b1000, v);
    chk(v == 8'h22, "R9", "status flag set", v, 8'h22);
    cpu_read(4'b1000, v);
    chk(v == 8'h20, "R10", "flag cleared by read", v, 8'h20);
    drq = 0;
    cpu_read(4'b0010, lo); cpu_read(4'b0010, hi);
    chk({hi, lo} == 16'h1237, "R8", "address advanced", {hi, lo}, 16'h1237);
    cpu_read(4'b0011, lo); cpu_read(4'b0011, hi);
    chk({hi, lo} == 16'h0000, "R8", "count exhausted", {hi, lo}, 0);
  endtask

  task automatic t_dir();
    logic [7:0] v;
    write16(4'b0110, 16'h00F0);
    write16(4'b0111, 16'h0000);
    cpu_write(4'b1000, 8'h88);
    drq = 4'b1000;
    do_xfer(3, 16'h00F0, 1, 1);
    drq = 0;
    cpu_read(4'b1000, v);
    chk(v == 8'h08, "R9", "ch3 flag", v, 8'h08);
  endtask

  task automatic t_prio();
    logic [7:0] lo, hi;
    write16(4'b0000, 16'h0100);
    write16(4'b0001, 16'h0005);
    write16(4'b0100, 16'h0200);
    write16(4'b0101, 16'h0005);
    cpu_write(4'b1001, 8'h00);
    cpu_write(4'b1000, 8'h05);
    drq = 4'b0101;
    do_xfer(0, 16'h0100, 0, 0);   // R4
    do_xfer(0, 16'h0101, 0, 0);   // R4
    drq = 0;
    cpu_write(4'b1001, 8'h01);
    drq = 4'b0101;
    do_xfer(2, 16'h0200, 0, 0);   // R5
    do_xfer(0, 16'h0102, 0, 0);   // R5
    do_xfer(2, 16'h0201, 0, 0);   // R5
    drq = 0;
    cpu_read(4'b0001, lo); cpu_read(4'b0001, hi);
    chk({hi, lo} == 16'h0002, "R5", "ch0 served three times", {hi, lo}, 2);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk); #1;
    t_reset();
    t_regs();
    t_ptr_reset();
    t_disabled();
    t_block();
    t_dir();
    t_prio();
    repeat (4) @(negedge clk);
    finish_run();
  end
endmodule